// File: doc/BRIEF.md
# World-ID Control Register Unit

This unit holds the three control registers that decide which world identifier a hart carries while it runs below machine mode. One is a machine-owned world ID applied to the less privileged modes. One is a supervisor-owned world ID. The third is a bitmap of the world IDs that machine mode hands down to supervisor mode. The core's CSR path presents an access with an address, write data, a write mask, a write strobe and a read strobe. One cycle later the unit answers with read data and an illegal-instruction flag. Every write is a masked read-modify-write, and each read returns the value held before that access.

Written world IDs are made legal before they are stored. A lower-mode ID must index a set bit of the permitted world-ID list. A supervisor ID must index a set bit of the delegation bitmap. When the written value is not allowed, the lowest allowed index is stored instead. The delegation bitmap is always trimmed to the permitted list. Static inputs select which extension levels are enabled and which privilege modes exist. These inputs gate each register. Whenever a stored world ID really changes, a one-cycle pulse asks the core to invalidate its address-translation cache.

Top module: `wid_csr_unit`

## Requirements
- R1: While reset is held and after it is released, the delegation bitmap is zero, and both world IDs equal the index of the lowest set bit of the permitted list.
- R2: A granted write stores `(old & ~mask) | (wdata & mask)`, subject to R3, R5 and R6. The response (`rsp_valid`, `rsp_rdata`, `rsp_illegal`) and the new register outputs appear one clock after the access. `rsp_rdata` carries the value held before the access.
- R3: The lower-mode world ID sits at address 0x7C0. A merged value of 32 or more, or one whose bit in the permitted list is 0, stores the lowest set index of that list instead.
- R4: Any access to the supervisor world ID at address 0x5C0 while the delegation bitmap is zero sets `rsp_illegal`, returns zero read data and changes no state.
- R5: A merged supervisor world ID of 32 or more, or one whose bit in the delegation bitmap is clear, stores the lowest set index of the delegation bitmap instead.
- R6: The delegation bitmap sits at address 0x7C1. After the masked merge it is ANDed with the permitted list.
- R7: `flush_req` is high for exactly the cycle after an access that changed the stored lower-mode or supervisor world ID. It is low at all other times.
- R8: An access to the lower-mode world ID is illegal unless `cfg_base_en` and `cfg_has_u` are both 1. An illegal access changes nothing.
- R9: An access to the supervisor world ID or the delegation bitmap is illegal unless `cfg_sup_en`, `cfg_has_s` and `cfg_has_u` are all 1. An illegal access changes nothing.
- R10: An access to any other address changes no state and raises neither `rsp_valid` nor `rsp_illegal`.
- R11: With `acc_wr` low, no register changes. With `acc_rd` low, `rsp_rdata` is zero. With both low, there is no access at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wid_list | input | 32 | Permitted world-ID bitmap; at least one bit set; static |
| cfg_base_en | input | 1 | Base world-ID extension enabled |
| cfg_sup_en | input | 1 | Supervisor world-ID extension enabled |
| cfg_has_s | input | 1 | Supervisor mode exists |
| cfg_has_u | input | 1 | User mode exists |
| acc_addr | input | 12 | CSR address of the access |
| acc_wr | input | 1 | Write strobe |
| acc_rd | input | 1 | Read strobe |
| acc_wdata | input | 32 | Write data |
| acc_wmask | input | 32 | Per-bit write mask |
| rsp_valid | output | 1 | Access hit one of the three registers (one cycle late) |
| rsp_rdata | output | 32 | Value before the access, or zero |
| rsp_illegal | output | 1 | Access was illegal |
| flush_req | output | 1 | Translation-cache invalidate pulse |
| lower_wid | output | 5 | Current lower-mode world ID |
| sup_wid | output | 5 | Current supervisor world ID |
| deleg_map | output | 32 | Current delegation bitmap |

## Verification
A corrupted register shows up on `lower_wid`, `sup_wid` or `deleg_map` one clock after the faulty access. The next read of that register also returns the wrong value in `rsp_rdata`. Errors in legalization, a fallback index that is not the lowest, or a delegation bitmap that is not trimmed all change those outputs in that same cycle. A gating mistake flips `rsp_illegal`. A flush fault appears as a `flush_req` pulse that is missing or extra in the cycle after the write. A small permitted list is swept over every world-ID value, so every index is checked in both the accepted case and the fallback case.

// File: rtl/wid_csr_pkg.sv
package wid_csr_pkg;

   typedef enum logic [1:0] {
      TGT_NONE  = 2'd0,
      TGT_LOWER = 2'd1,
      TGT_SUP   = 2'd2,
      TGT_DELEG = 2'd3
   } wid_tgt_e;

endpackage

// File: rtl/wid_lowest_set.sv
module wid_lowest_set #(
   parameter int N = 32,
   parameter int W = 5
) (
   input  logic [N-1:0] vec,
   output logic [W-1:0] idx
);

   logic [W-1:0] chain [N+1];

   assign chain[N] = '0;

   for (genvar i = N - 1; i >= 0; i--) begin : g_scan
      assign chain[i] = vec[i] ? W'(i) : chain[i+1];
   end

   assign idx = chain[0];

endmodule

// File: rtl/wid_legalize.sv
module wid_legalize #(
   parameter int XLEN    = 32,
   parameter int WID_W   = 5,
   parameter int NUM_WID = 32
) (
   input  logic [WID_W-1:0]   cur,
   input  logic [XLEN-1:0]    wdata,
   input  logic [XLEN-1:0]    wmask,
   input  logic [NUM_WID-1:0] allow,
   output logic [WID_W-1:0]   nxt
);

   localparam int HI_W = XLEN - WID_W;

   logic [XLEN-1:0]  cur_ext;
   logic [XLEN-1:0]  merged;
   logic             in_range;
   logic             permitted;
   logic [WID_W-1:0] fallback;

   assign cur_ext   = {{HI_W{1'b0}}, cur};
   assign merged    = (cur_ext & ~wmask) | (wdata & wmask);
   assign in_range  = (merged[XLEN-1:WID_W] == '0);
   assign permitted = in_range && allow[merged[WID_W-1:0]];

   wid_lowest_set #(
      .N (NUM_WID),
      .W (WID_W)
   ) i_fallback (
      .vec (allow),
      .idx (fallback)
   );

   assign nxt = permitted ? merged[WID_W-1:0] : fallback;

endmodule

// File: rtl/wid_csr_gate.sv
module wid_csr_gate
   import wid_csr_pkg::*;
#(
   parameter int               ADDR_W     = 12,
   parameter logic [ADDR_W-1:0] ADDR_LOWER = 12'h7C0,
   parameter logic [ADDR_W-1:0] ADDR_SUP   = 12'h5C0,
   parameter logic [ADDR_W-1:0] ADDR_DELEG = 12'h7C1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              access,
   input  logic              base_en,
   input  logic              sup_en,
   input  logic              has_s,
   input  logic              has_u,
   input  logic              deleg_nz,
   output wid_tgt_e          tgt,
   output logic              granted,
   output logic              illegal
);

   logic lower_ok;
   logic sup_ok;
   logic refuse;

   always_comb begin
      if (addr == ADDR_LOWER)      tgt = TGT_LOWER;
      else if (addr == ADDR_SUP)   tgt = TGT_SUP;
      else if (addr == ADDR_DELEG) tgt = TGT_DELEG;
      else                         tgt = TGT_NONE;
   end

   assign lower_ok = base_en & has_u;
   assign sup_ok   = sup_en & has_s & has_u;

   always_comb begin
      unique case (tgt)
         TGT_LOWER: refuse = !lower_ok;
         TGT_SUP:   refuse = !sup_ok || !deleg_nz;
         TGT_DELEG: refuse = !sup_ok;
         default:   refuse = 1'b0;
      endcase
   end

   assign illegal = access && (tgt != TGT_NONE) && refuse;
   assign granted = access && (tgt != TGT_NONE) && !refuse;

endmodule

// File: rtl/wid_csr_unit.sv
module wid_csr_unit
   import wid_csr_pkg::*;
#(
   parameter int                XLEN       = 32,
   parameter int                WID_W      = 5,
   parameter int                ADDR_W     = 12,
   parameter logic [ADDR_W-1:0] ADDR_LOWER = 12'h7C0,
   parameter logic [ADDR_W-1:0] ADDR_SUP   = 12'h5C0,
   parameter logic [ADDR_W-1:0] ADDR_DELEG = 12'h7C1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [(1<<WID_W)-1:0] cfg_wid_list,
   input  logic                 cfg_base_en,
   input  logic                 cfg_sup_en,
   input  logic                 cfg_has_s,
   input  logic                 cfg_has_u,
   input  logic [ADDR_W-1:0]    acc_addr,
   input  logic                 acc_wr,
   input  logic                 acc_rd,
   input  logic [XLEN-1:0]      acc_wdata,
   input  logic [XLEN-1:0]      acc_wmask,
   output logic                 rsp_valid,
   output logic [XLEN-1:0]      rsp_rdata,
   output logic                 rsp_illegal,
   output logic                 flush_req,
   output logic [WID_W-1:0]     lower_wid,
   output logic [WID_W-1:0]     sup_wid,
   output logic [(1<<WID_W)-1:0] deleg_map
);

   localparam int NUM_WID = 1 << WID_W;
   localparam int PAD_W   = XLEN - NUM_WID;
   localparam int WPAD_W  = XLEN - WID_W;

   if (XLEN < NUM_WID) begin : g_bad_xlen
      $error("wid_csr_unit: XLEN must hold the whole world-ID bitmap");
   end
   if (WID_W < 1 || WID_W > 6) begin : g_bad_widw
      $error("wid_csr_unit: WID_W out of supported range");
   end
   if (ADDR_LOWER == ADDR_SUP || ADDR_LOWER == ADDR_DELEG || ADDR_SUP == ADDR_DELEG) begin : g_bad_addr
      $error("wid_csr_unit: register addresses must differ");
   end

   // ---------------- access gating ----------------
   wid_tgt_e tgt;
   logic     access;
   logic     granted;
   logic     illegal;

   logic [WID_W-1:0]   lower_q, sup_q;
   logic [NUM_WID-1:0] deleg_q;

   assign access = acc_wr | acc_rd;

   wid_csr_gate #(
      .ADDR_W     (ADDR_W),
      .ADDR_LOWER (ADDR_LOWER),
      .ADDR_SUP   (ADDR_SUP),
      .ADDR_DELEG (ADDR_DELEG)
   ) i_gate (
      .addr     (acc_addr),
      .access   (access),
      .base_en  (cfg_base_en),
      .sup_en   (cfg_sup_en),
      .has_s    (cfg_has_s),
      .has_u    (cfg_has_u),
      .deleg_nz (|deleg_q),
      .tgt      (tgt),
      .granted  (granted),
      .illegal  (illegal)
   );

   // ---------------- legalization ----------------
   logic [WID_W-1:0] lower_legal;
   logic [WID_W-1:0] sup_legal;
   logic [WID_W-1:0] reset_wid;

   wid_legalize #(
      .XLEN    (XLEN),
      .WID_W   (WID_W),
      .NUM_WID (NUM_WID)
   ) i_lower_fix (
      .cur   (lower_q),
      .wdata (acc_wdata),
      .wmask (acc_wmask),
      .allow (cfg_wid_list),
      .nxt   (lower_legal)
   );

   wid_legalize #(
      .XLEN    (XLEN),
      .WID_W   (WID_W),
      .NUM_WID (NUM_WID)
   ) i_sup_fix (
      .cur   (sup_q),
      .wdata (acc_wdata),
      .wmask (acc_wmask),
      .allow (deleg_q),
      .nxt   (sup_legal)
   );

   wid_lowest_set #(
      .N (NUM_WID),
      .W (WID_W)
   ) i_reset_pick (
      .vec (cfg_wid_list),
      .idx (reset_wid)
   );

   // ---------------- next state ----------------
   logic               do_write;
   logic [XLEN-1:0]    deleg_ext;
   logic [XLEN-1:0]    deleg_merged;
   logic [WID_W-1:0]   lower_d, sup_d;
   logic [NUM_WID-1:0] deleg_d;
   logic [XLEN-1:0]    old_val;

   assign do_write     = granted & acc_wr;
   assign deleg_merged = (deleg_ext & ~acc_wmask) | (acc_wdata & acc_wmask);

   if (PAD_W > 0) begin : g_deleg_pad
      assign deleg_ext = {{PAD_W{1'b0}}, deleg_q};
   end else begin : g_deleg_nopad
      assign deleg_ext = deleg_q;
   end

   always_comb begin
      lower_d = lower_q;
      sup_d   = sup_q;
      deleg_d = deleg_q;
      if (do_write) begin
         unique case (tgt)
            TGT_LOWER: lower_d = lower_legal;
            TGT_SUP:   sup_d   = sup_legal;
            TGT_DELEG: deleg_d = deleg_merged[NUM_WID-1:0] & cfg_wid_list;
            default:   ;
         endcase
      end
   end

   always_comb begin
      unique case (tgt)
         TGT_LOWER: old_val = {{WPAD_W{1'b0}}, lower_q};
         TGT_SUP:   old_val = {{WPAD_W{1'b0}}, sup_q};
         TGT_DELEG: old_val = deleg_ext;
         default:   old_val = '0;
      endcase
   end

   // ---------------- registers ----------------
   logic            rsp_valid_q, rsp_illegal_q, flush_q;
   logic [XLEN-1:0] rdata_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lower_q       <= reset_wid;
         sup_q         <= reset_wid;
         deleg_q       <= '0;
         rsp_valid_q   <= 1'b0;
         rsp_illegal_q <= 1'b0;
         rdata_q       <= '0;
         flush_q       <= 1'b0;
      end else begin
         lower_q       <= lower_d;
         sup_q         <= sup_d;
         deleg_q       <= deleg_d;
         rsp_valid_q   <= access && (tgt != TGT_NONE);
         rsp_illegal_q <= illegal;
         rdata_q       <= (granted && acc_rd) ? old_val : '0;
         flush_q       <= (lower_d != lower_q) || (sup_d != sup_q);
      end
   end

   assign rsp_valid   = rsp_valid_q;
   assign rsp_illegal = rsp_illegal_q;
   assign rsp_rdata   = rdata_q;
   assign flush_req   = flush_q;
   assign lower_wid   = lower_q;
   assign sup_wid     = sup_q;
   assign deleg_map   = deleg_q;

   // ---------------- assertions ----------------
   AST_FLUSH_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      flush_req == ((lower_wid != $past(lower_wid)) || (sup_wid != $past(sup_wid)))); // R7

   AST_ILLEGAL_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_illegal |-> ($stable(lower_wid) && $stable(sup_wid) && $stable(deleg_map))); // R4

   AST_ILLEGAL_HAS_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_illegal |-> (rsp_valid && rsp_rdata == '0)); // R4

   AST_DELEG_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
      (deleg_map & ~cfg_wid_list) == '0); // R6

   AST_LOWER_PERMITTED: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wid_list[lower_wid]); // R3

   AST_SUP_MOVE_DELEGATED: assert property (@(posedge clk) disable iff (!rst_n)
      (sup_wid != $past(sup_wid)) |-> deleg_map[sup_wid]); // R5

   AST_UNMAPPED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      ((acc_wr || acc_rd) && acc_addr != ADDR_LOWER && acc_addr != ADDR_SUP &&
       acc_addr != ADDR_DELEG) |=> (!rsp_valid && !rsp_illegal &&
       $stable(lower_wid) && $stable(sup_wid) && $stable(deleg_map))); // R10

   AST_NO_WRITE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_wr |=> ($stable(lower_wid) && $stable(sup_wid) && $stable(deleg_map))); // R11

endmodule

// File: tb/test_wid_csr_unit.sv
module test_wid_csr_unit;

   localparam int CLK_PERIOD = 10;
   localparam logic [11:0] A_LOW = 12'h7C0;
   localparam logic [11:0] A_SUP = 12'h5C0;
   localparam logic [11:0] A_DEL = 12'h7C1;
   localparam logic [31:0] FULL  = 32'hFFFF_FFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] cfg_wid_list = 32'h1;
   logic        cfg_base_en = 1'b1, cfg_sup_en = 1'b1, cfg_has_s = 1'b1, cfg_has_u = 1'b1;
   logic [11:0] acc_addr = '0;
   logic        acc_wr = 1'b0, acc_rd = 1'b0;
   logic [31:0] acc_wdata = '0, acc_wmask = '0;
   logic        rsp_valid, rsp_illegal, flush_req;
   logic [31:0] rsp_rdata, deleg_map;
   logic [4:0]  lower_wid, sup_wid;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   int unsigned m_low, m_sup;
   logic [31:0] m_del;

   always #(CLK_PERIOD / 2) clk = ~clk;

   wid_csr_unit i_wid_csr_unit (
      .clk, .rst_n, .cfg_wid_list, .cfg_base_en, .cfg_sup_en, .cfg_has_s, .cfg_has_u,
      .acc_addr, .acc_wr, .acc_rd, .acc_wdata, .acc_wmask,
      .rsp_valid, .rsp_rdata, .rsp_illegal, .flush_req,
      .lower_wid, .sup_wid, .deleg_map
   );

   function automatic int unsigned lowest(logic [31:0] v);
      for (int i = 0; i < 32; i++) if (v[i]) return i;
      return 0;
   endfunction

   task automatic check(string tag, logic [108:0] got, logic [108:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   function automatic logic [108:0] pack_out();
      return {rsp_valid, rsp_illegal, rsp_rdata, flush_req, 5'(lower_wid), 5'(sup_wid), deleg_map, 2'b00};
   endfunction

   task automatic do_reset(logic [31:0] list, string tag);
      @(negedge clk);
      rst_n = 1'b0;
      cfg_wid_list = list;
      repeat (2) @(negedge clk);
      m_low = lowest(list);
      m_sup = lowest(list);
      m_del = '0;
      check({tag, " R1 during reset"}, pack_out(),
            {1'b0, 1'b0, 32'h0, 1'b0, 5'(m_low), 5'(m_sup), 32'h0, 2'b00});
      rst_n = 1'b1;
      @(negedge clk);
      check({tag, " R1 after reset"}, pack_out(),
            {1'b0, 1'b0, 32'h0, 1'b0, 5'(m_low), 5'(m_sup), 32'h0, 2'b00});
   endtask

   task automatic acc(logic [11:0] a, bit wr, bit rd, logic [31:0] d, logic [31:0] m, string tag);
      int          kind;
      bit          ev, ei, g_low, g_sup;
      logic [31:0] old, merged, erd;
      int unsigned o_low, o_sup;
      kind  = (a == A_LOW) ? 1 : (a == A_SUP) ? 2 : (a == A_DEL) ? 3 : 0;
      g_low = cfg_base_en && cfg_has_u;
      g_sup = cfg_sup_en && cfg_has_s && cfg_has_u;
      ev    = (kind != 0) && (wr || rd);
      ei    = ev && ((kind == 1) ? !g_low : (kind == 2) ? (!g_sup || m_del == 0) : !g_sup);
      old   = (kind == 1) ? 32'(m_low) : (kind == 2) ? 32'(m_sup) : (kind == 3) ? m_del : 32'h0;
      erd   = (ev && !ei && rd) ? old : 32'h0;
      o_low = m_low;
      o_sup = m_sup;
      merged = (old & ~m) | (d & m);
      if (ev && !ei && wr) begin
         if (kind == 1) m_low = (merged < 32 && cfg_wid_list[merged[4:0]]) ? merged : lowest(cfg_wid_list);
         if (kind == 2) m_sup = (merged < 32 && m_del[merged[4:0]]) ? merged : lowest(m_del);
         if (kind == 3) m_del = merged & cfg_wid_list;
      end
      @(negedge clk);
      acc_addr = a; acc_wr = wr; acc_rd = rd; acc_wdata = d; acc_wmask = m;
      @(negedge clk);
      acc_wr = 1'b0; acc_rd = 1'b0; acc_addr = 12'h000;
      check(tag, pack_out(),
            {ev, ei, erd, (m_low != o_low) || (m_sup != o_sup), 5'(m_low), 5'(m_sup), m_del, 2'b00});
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      do_reset(32'h0000_0F0A, "cfgA");

      // R3: sweep every lower-mode value with full mask
      for (int v = 0; v < 32; v++) acc(A_LOW, 1, 1, 32'(v), FULL, "R3 lower sweep / R7 flush");
      acc(A_LOW, 1, 1, 32'h0000_0023, FULL, "R3 out of range value");
      acc(A_LOW, 1, 1, 32'd9, FULL, "R3 set 9");
      acc(A_LOW, 1, 1, 32'd9, FULL, "R7 same value no flush");
      // R2: partial masks
      for (int mk = 0; mk < 32; mk++) acc(A_LOW, 1, 1, 32'h0000_0003, 32'(mk), "R2 masked merge");
      acc(A_LOW, 0, 1, 32'h0, FULL, "R11 read only");
      acc(A_LOW, 1, 0, 32'd11, FULL, "R11 write without read strobe");
      acc(A_LOW, 0, 0, 32'd8, FULL, "R11 no strobe");

      // R4: supervisor ID with empty delegation
      acc(A_SUP, 1, 1, 32'd3, FULL, "R4 sup with zero deleg");
      acc(A_SUP, 0, 1, 32'd0, FULL, "R4 sup read zero deleg");

      // R6: delegation trimming
      acc(A_DEL, 1, 1, FULL, FULL, "R6 deleg all ones");
      acc(A_DEL, 1, 1, 32'h0000_00F0, 32'h0000_0FFF, "R6 deleg partial");
      acc(A_DEL, 1, 1, 32'h0000_0A02, 32'h0000_0F0F, "R6 deleg masked");
      acc(A_DEL, 0, 1, 32'h0, FULL, "R6 deleg read");

      // R5: supervisor sweep
      for (int v = 0; v < 32; v++) acc(A_SUP, 1, 1, 32'(v), FULL, "R5 sup sweep / R7 flush");
      acc(A_SUP, 1, 1, 32'h0000_0101, FULL, "R5 sup out of range");
      acc(A_SUP, 1, 1, 32'd11, FULL, "R5 sup set 11");
      acc(A_DEL, 1, 1, 32'h0000_0002, FULL, "R6 shrink deleg keeps sup");
      acc(A_SUP, 0, 1, 32'h0, FULL, "R5 stale sup read");
      acc(A_SUP, 1, 1, 32'd11, FULL, "R5 sup rewrite falls back");

      // R8 / R9: gating
      cfg_base_en = 1'b0;
      acc(A_LOW, 1, 1, 32'd3, FULL, "R8 base disabled");
      cfg_base_en = 1'b1; cfg_has_u = 1'b0;
      acc(A_LOW, 1, 1, 32'd3, FULL, "R8 no user mode");
      acc(A_DEL, 1, 1, FULL, FULL, "R9 no user mode deleg");
      cfg_has_u = 1'b1; cfg_sup_en = 1'b0;
      acc(A_SUP, 1, 1, 32'd1, FULL, "R9 sup ext disabled");
      acc(A_DEL, 1, 1, FULL, FULL, "R9 sup ext disabled deleg");
      acc(A_LOW, 1, 1, 32'd10, FULL, "R8 lower still legal");
      cfg_sup_en = 1'b1; cfg_has_s = 1'b0;
      acc(A_SUP, 0, 1, 32'd0, FULL, "R9 no supervisor mode");
      acc(A_DEL, 1, 1, 32'h0, FULL, "R9 no supervisor mode deleg");
      cfg_has_s = 1'b1;

      // R10: unmapped addresses
      acc(12'h7C2, 1, 1, FULL, FULL, "R10 unmapped");
      acc(12'h000, 1, 1, FULL, FULL, "R10 unmapped zero");
      acc(12'h5C1, 1, 1, 32'd1, FULL, "R10 unmapped near sup");

      // second configuration: only the top ID permitted
      do_reset(32'h8000_0000, "cfgB");
      for (int v = 28; v < 32; v++) acc(A_LOW, 1, 1, 32'(v), FULL, "R3 single permitted");
      acc(A_DEL, 1, 1, FULL, FULL, "R6 single permitted deleg");
      acc(A_SUP, 1, 1, 32'd0, FULL, "R5 single permitted sup");

      // third configuration: every ID permitted
      do_reset(FULL, "cfgC");
      for (int v = 0; v < 32; v++) acc(A_LOW, 1, 1, 32'(31 - v), FULL, "R3 all permitted");
      acc(A_DEL, 1, 1, 32'h0000_5500, FULL, "R6 all permitted deleg");
      for (int v = 0; v < 32; v++) acc(A_SUP, 1, 1, 32'(v), 32'h0000_001F, "R5 sup vs sparse deleg");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule